// File: doc/BRIEF.md
# Register File with Same-Cycle Write Forwarding

This block is the architectural register store for the decode stage of a five-stage in-order pipeline. It holds 32 general registers of 32 bits each. It has two combinational read ports and one write port that commits on the rising clock edge. Writes come from the writeback stage, and the two reads serve the operand fetch of the instruction in decode.

A read port can name the register that writeback is committing in the same cycle. In that case the port returns the incoming write data, not the stale stored word. This is equivalent to the write landing before the read within the cycle. The decode-stage instruction therefore never picks up an old value left behind by an older instruction. Register index 0 is a constant zero: it is never written and never forwarded.

Top module: `regBankFwd`

## Requirements
- R1: A read of register index 0 on either port returns 32'h0 in all cycles, including when a write with enable high targets index 0 in that same cycle (no forwarding for index 0).
- R2: A write with wrEn high and wrAddr 0 changes no register; a later read of index 0 still returns 0.
- R3: When wrEn is high and wrAddr is nonzero, a value written at a rising edge is returned by a read of that index in every later cycle until the index is written again.
- R4: In a cycle where wrEn is high, wrAddr is nonzero and rdAddrA equals wrAddr, rdDataA equals wrData in that same cycle, before the edge.
- R5: The same forwarding applies to port B independently: in a cycle where wrEn is high, wrAddr is nonzero and rdAddrB equals wrAddr, rdDataB equals wrData.
- R6: Both ports may forward in the same cycle, including when rdAddrA and rdAddrB are both equal to wrAddr.
- R7: When wrEn is low, neither port forwards and no register changes: each port returns the stored value even if its address equals wrAddr, and a later read shows the old contents.
- R8: After reset deasserts, every register reads 0 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rstN | input | 1 | Active-low synchronous reset; clears all registers |
| rdAddrA | input | 5 | Read address, port A |
| rdAddrB | input | 5 | Read address, port B |
| wrEn | input | 1 | Write enable from writeback |
| wrAddr | input | 5 | Destination register of the write |
| wrData | input | 32 | Data being written |
| rdDataA | output | 32 | Read data, port A (combinational) |
| rdDataB | output | 32 | Read data, port B (combinational) |

## Verification
Forwarding and a stored-value read can fall in the same cycle. Either port may pick up writeback data while the other returns the array, or both ports may forward at once. The bench provokes this by biasing the random read addresses toward the current write address. It also drives directed cycles where both ports name the write target, where the enable is low with matching addresses, and where the target is index 0. Each output is judged before the clock edge against a bench shadow array plus the forwarding rule. The same read is then repeated after the edge to confirm that the write committed, or did not.

// File: rtl/regBankFwdPkg.sv
package regBankFwdPkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_N  = 32;
  localparam int unsigned ADDR_W = $clog2(REG_N);

  typedef struct packed {
    logic               commit;
    logic [ADDR_W-1:0]  commitIdx;
    logic               fwdA;
    logic               fwdB;
  } ctlStrobes_t;
endpackage

// File: rtl/regBankCtl.sv
module regBankCtl
  import regBankFwdPkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  output ctlStrobes_t   strobes
);
  logic wrLive;

  always_comb begin
    wrLive            = wrEn && (wrAddr != '0);
    strobes.commit    = wrLive;
    strobes.commitIdx = wrAddr;
    strobes.fwdA      = wrLive && (rdAddrA == wrAddr);
    strobes.fwdB      = wrLive && (rdAddrB == wrAddr);
  end

  // R1: a forward strobe never fires for register zero
  assert_no_fwd_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fwdA |-> rdAddrA != '0) and (strobes.fwdB |-> rdAddrB != '0));
  // R7: no forward strobe and no commit while the enable is low
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strobes.fwdA || strobes.fwdB || strobes.commit));
endmodule

// File: rtl/regBankData.sv
module regBankData
  import regBankFwdPkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned N  = REG_N,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB
);
  logic [DW-1:0] regs [N];

  assign regs[0] = '0;

  for (genvar i = 1; i < N; i++) begin : gRow
    always_ff @(posedge clk) begin
      if (!rstN)
        regs[i] <= '0;
      else if (strobes.commit && (strobes.commitIdx == AW'(i)))
        regs[i] <= wrData;
    end
  end

  assign rdDataA = strobes.fwdA ? wrData : regs[rdAddrA];
  assign rdDataB = strobes.fwdB ? wrData : regs[rdAddrB];

  // R1: register zero reads as zero on both ports
  assert_zero_reads_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0 |-> rdDataA == '0) and (rdAddrB == '0 |-> rdDataB == '0));
  // R3: a committed write is visible at the same index one cycle later
  assert_write_visible_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> regs[$past(strobes.commitIdx)] == $past(wrData));
  // R4/R5: forwarding presents the write data on the port
  assert_fwd_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fwdA |-> rdDataA == wrData);
  assert_fwd_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fwdB |-> rdDataB == wrData);
endmodule

// File: rtl/regBankFwd.sv
module regBankFwd
  import regBankFwdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  ctlStrobes_t strobes;

  regBankCtl #(.AW(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes));

  regBankData #(.DW(DATA_W), .N(REG_N), .AW(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB), .wrData(wrData), .rdDataA(rdDataA), .rdDataB(rdDataB));
endmodule

// File: tb/regBankFwd_test.sv
`timescale 1ns/1ps
module regBankFwd_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic        wrEn = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdDataA, rdDataB;
  logic [31:0] shadow [32];
  int checks = 0, errors = 0;
  int seed = 32'h5eed1234;

  always #5 clk = ~clk;

  regBankFwd uut (.*);

  function automatic logic [31:0] expRead(input logic [4:0] a);
    if (a == 0) return 32'h0;
    if (wrEn && wrAddr != 0 && a == wrAddr) return wrData;
    return shadow[a];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check mid-low, then commit at posedge
  task automatic cyc(input string req, input logic [4:0] a, input logic [4:0] b,
                     input logic we, input logic [4:0] wa, input logic [31:0] wd);
    @(negedge clk);
    rdAddrA = a; rdAddrB = b; wrEn = we; wrAddr = wa; wrData = wd;
    #2;
    check({req, " portA"}, rdDataA, expRead(a));
    check({req, " portB"}, rdDataB, expRead(b));
    @(posedge clk);
    if (we && wa != 0) shadow[wa] = wd;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    for (int i = 0; i < 32; i++) shadow[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R8 reset state
    for (int i = 0; i < 32; i++) cyc("R8", 5'(i), 5'(31 - i), 0, 0, 0);
    // R2 / R1 write to zero, forward suppressed
    cyc("R1", 0, 0, 1, 0, 32'hdeadbeef);
    cyc("R2", 0, 0, 0, 0, 0);
    // R3 store then read later
    cyc("R3", 1, 2, 1, 7, 32'h11112222);
    cyc("R3", 7, 3, 0, 0, 0);
    // R4 port A forward, B stored
    cyc("R4", 9, 7, 1, 9, 32'h0a0a0a0a);
    // R5 port B forward
    cyc("R5", 7, 12, 1, 12, 32'hc0c0c0c0);
    // R6 both forward same index
    cyc("R6", 7, 7, 1, 7, 32'h77777777);
    cyc("R3", 7, 12, 0, 0, 0);
    // R7 enable low with matching addresses
    cyc("R7", 9, 9, 0, 9, 32'hffffffff);
    cyc("R7", 9, 9, 0, 0, 0);
    // random with bias toward matches
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] wa, a, b;
      wa = 5'($urandom);
      a  = ($urandom % 3 == 0) ? wa : 5'($urandom);
      b  = ($urandom % 3 == 0) ? wa : 5'($urandom);
      cyc("R6", a, b, 1'($urandom), wa, $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule